// File: doc/BRIEF.md
# Ethernet receive frame filter

This block sits behind the line decoder of an Ethernet receiver. It watches a byte stream qualified by a carrier signal and hunts for the start-of-frame delimiter. It passes the first six frame bytes through a programmable destination-address filter, and only for frames that pass does it write the bytes into a single-frame receive buffer. The frame check sequence is verified as the bytes go by.

When carrier drops, the block finishes writing and latches the frame length together with a small status word: CRC verdict, runt flag and match kind. It then decides, under two configuration bits, whether to raise a level interrupt to the host. A reported frame stays owned by the host until a release pulse. An acceptable frame that arrives while the buffer is still owned is thrown away and counted as missed.

Top module: `eth_rx_filter`

## Requirements
- R1: Bytes received before and including the first 0xD5 after carrier rises are never written; buffer address 0 receives the first destination-address byte.
- R2: The destination address (first wire byte compared with station_addr_i[47:40]) passes on any enabled criterion. The criteria are exact station match, all-ones broadcast, multicast (bit 0 of the first byte set), or promiscuous. match_o reports the highest-priority hit: 0 station, 1 broadcast, 2 multicast, 3 promiscuous only.
- R3: A frame whose address passes no enabled criterion produces no buffer write, no interrupt, and no change to frame_len_o or status.
- R4: For an accepted frame, every byte from the destination address through the FCS is written once, in order, to consecutive addresses starting at 0.
- R5: crc_ok_o is 1 exactly when the CRC-32 (reflected polynomial 0xEDB88320, preset all ones) over all bytes including the FCS leaves the residue 0xDEBB20E3 in the LSB-first register. This is the same check value as 0xC704DD7B read MSB first.
- R6: A frame ends when carrier drops. frame_len_o then holds the byte count from destination address through FCS, and runt_o is 1 when that count is below 64.
- R7: A finished accepted frame raises irq_o unless its CRC is bad and irq_bad_crc_en_i is 0, or it is a runt and irq_runt_en_i is 0. A suppressed frame leaves frame_len_o and status unchanged and does not hold the buffer.
- R8: irq_o stays high, with length and status frozen, until a host_release_i pulse, which clears it on the next cycle.
- R9: An acceptable frame that arrives while irq_o is high is not written and increments miss_cnt_o, which saturates. Frames rejected by the filter do not count.
- R10: A frame whose carrier drops before six bytes follow the delimiter is dropped without writes or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_crs_i | input | 1 | Carrier present |
| rx_valid_i | input | 1 | rx_data_i holds a new byte |
| rx_data_i | input | 8 | Received NRZ byte |
| station_addr_i | input | 48 | Station address, [47:40] is first on the wire |
| ucast_en_i | input | 1 | Accept exact station match |
| bcast_en_i | input | 1 | Accept broadcast |
| mcast_en_i | input | 1 | Accept any multicast |
| promisc_en_i | input | 1 | Accept every address |
| irq_bad_crc_en_i | input | 1 | Report frames with bad CRC |
| irq_runt_en_i | input | 1 | Report runt frames |
| host_release_i | input | 1 | Host frees the buffer, one-cycle pulse |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | BUF_AW | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write byte |
| frame_len_o | output | LEN_W | Latched frame length |
| crc_ok_o | output | 1 | Latched CRC verdict |
| runt_o | output | 1 | Latched runt flag |
| match_o | output | 2 | Latched match kind |
| irq_o | output | 1 | Receive interrupt, level |
| miss_cnt_o | output | MISS_W | Missed frame count |

## Verification
The bench targets the length boundary at 63 and 64 bytes. A design with an off-by-one compare would flag a legal minimum frame as a runt, or let a short one through unflagged. It sends a broadcast with broadcast disabled but multicast enabled, where a wrong priority order or a filter blind to the group bit would drop the frame or report the wrong kind. Corrupted frames are run under both settings of the bad-CRC enable, which catches a design that reports them anyway or leaks their length into the status. A second frame sent while the buffer is still owned, plus a frame cut off inside its address, catch designs that overwrite held data or store fragments.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam int          DA_BYTES    = 6;

  typedef enum logic [1:0] {
    MT_INDIV   = 2'd0,
    MT_BCAST   = 2'd1,
    MT_MCAST   = 2'd2,
    MT_PROMISC = 2'd3
  } match_e;

  function automatic logic [31:0] crc32_step(logic [31:0] crc, logic [7:0] data);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_R;
      else                c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_addr_filter.sv
module rx_addr_filter import eth_rx_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        shift_i,
  input  logic [7:0]  byte_i,
  input  logic [47:0] station_addr_i,
  input  logic        ucast_en_i,
  input  logic        bcast_en_i,
  input  logic        mcast_en_i,
  input  logic        promisc_en_i,
  output logic [7:0]  oldest_o,
  output logic        accept_o,
  output match_e      match_o
);

  // Six-byte window: holds the address for the decision, then delays data for the buffer
  logic [47:0] win_q;
  logic [47:0] cand;
  logic        hit_ind, hit_bc, hit_mc, hit_pr;

  assign cand = {win_q[39:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (shift_i) win_q <= cand;
  end

  assign oldest_o = win_q[47:40];

  always_comb begin
    hit_ind = ucast_en_i && (cand == station_addr_i);
    hit_bc  = bcast_en_i && (cand == '1);
    hit_mc  = mcast_en_i && cand[40];
    hit_pr  = promisc_en_i;
    accept_o = hit_ind | hit_bc | hit_mc | hit_pr;
    if (hit_ind)     match_o = MT_INDIV;
    else if (hit_bc) match_o = MT_BCAST;
    else if (hit_mc) match_o = MT_MCAST;
    else             match_o = MT_PROMISC;
  end

endmodule

// File: rtl/rx_crc_chk.sv
module rx_crc_chk import eth_rx_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic       good_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (clear_i) crc_q <= '1;
    else if (en_i)    crc_q <= crc32_step(crc_q, byte_i);
  end

  assign good_o = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter import eth_rx_pkg::*; #(
  parameter int BUF_AW  = 11,
  parameter int LEN_W   = 16,
  parameter int MISS_W  = 8,
  parameter int MIN_LEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_crs_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic [47:0]       station_addr_i,
  input  logic              ucast_en_i,
  input  logic              bcast_en_i,
  input  logic              mcast_en_i,
  input  logic              promisc_en_i,
  input  logic              irq_bad_crc_en_i,
  input  logic              irq_runt_en_i,
  input  logic              host_release_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              crc_ok_o,
  output logic              runt_o,
  output logic [1:0]        match_o,
  output logic              irq_o,
  output logic [MISS_W-1:0] miss_cnt_o
);

  localparam logic [LEN_W-1:0]  LEN_MAX  = '1;
  localparam logic [LEN_W-1:0]  LEN_MIN  = LEN_W'(MIN_LEN);
  localparam logic [BUF_AW-1:0] WPTR_MAX = '1;
  localparam logic [MISS_W-1:0] MISS_MAX = '1;
  localparam logic [2:0]        FL_LAST  = 3'(DA_BYTES - 1);
  localparam logic [LEN_W-1:0]  DA_LAST  = LEN_W'(DA_BYTES - 1);

  typedef enum logic [2:0] {ST_HUNT, ST_ADDR, ST_BODY, ST_FLUSH, ST_DROP} st_e;

  st_e               st_q, st_d;
  logic [LEN_W-1:0]  cnt_q;
  logic [BUF_AW-1:0] wptr_q;
  logic              wfull_q;
  logic [2:0]        fl_q;
  logic              held_q;
  match_e            match_q, mout_q;
  logic [LEN_W-1:0]  len_q;
  logic              crc_ok_q, runt_q;
  logic [MISS_W-1:0] miss_q;
  logic              we_q;
  logic [BUF_AW-1:0] waddr_q;
  logic [7:0]        wdata_q;

  logic              byte_in, sof, shift, crc_en, wr, last_da, fin, notify, runt_now;
  logic [7:0]        flt_byte, oldest;
  logic              flt_accept, crc_good;
  match_e            flt_match;

  assign byte_in  = rx_crs_i && rx_valid_i;
  assign sof      = (st_q == ST_HUNT) && byte_in && (rx_data_i == SFD_BYTE);
  assign crc_en   = (st_q == ST_ADDR || st_q == ST_BODY) && byte_in;
  assign shift    = crc_en || (st_q == ST_FLUSH);
  assign flt_byte = (st_q == ST_FLUSH) ? 8'h00 : rx_data_i;
  assign wr       = ((st_q == ST_BODY && byte_in) || st_q == ST_FLUSH) && !wfull_q;
  assign last_da  = (st_q == ST_ADDR) && byte_in && (cnt_q == DA_LAST);
  assign fin      = (st_q == ST_FLUSH) && (fl_q == FL_LAST);
  assign runt_now = cnt_q < LEN_MIN;
  assign notify   = fin && (crc_good || irq_bad_crc_en_i) && (!runt_now || irq_runt_en_i);

  rx_addr_filter i_filter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .shift_i        (shift),
    .byte_i         (flt_byte),
    .station_addr_i (station_addr_i),
    .ucast_en_i     (ucast_en_i),
    .bcast_en_i     (bcast_en_i),
    .mcast_en_i     (mcast_en_i),
    .promisc_en_i   (promisc_en_i),
    .oldest_o       (oldest),
    .accept_o       (flt_accept),
    .match_o        (flt_match)
  );

  rx_crc_chk i_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sof),
    .en_i    (crc_en),
    .byte_i  (rx_data_i),
    .good_o  (crc_good)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HUNT:  if (sof) st_d = ST_ADDR;
      ST_ADDR: begin
        if (!rx_crs_i)    st_d = ST_HUNT;
        else if (last_da) st_d = (flt_accept && !held_q) ? ST_BODY : ST_DROP;
      end
      ST_BODY:  if (!rx_crs_i) st_d = ST_FLUSH;
      ST_FLUSH: if (fin) st_d = ST_HUNT;
      ST_DROP:  if (!rx_crs_i) st_d = ST_HUNT;
      default:  st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      wptr_q  <= '0;
      wfull_q <= 1'b0;
      fl_q    <= '0;
      match_q <= MT_INDIV;
    end else begin
      st_q <= st_d;
      if (sof) begin
        cnt_q   <= '0;
        wptr_q  <= '0;
        wfull_q <= 1'b0;
        fl_q    <= '0;
      end else begin
        if (crc_en && cnt_q != LEN_MAX) cnt_q <= cnt_q + 1'b1;
        if (wr) begin
          wptr_q <= wptr_q + 1'b1;
          if (wptr_q == WPTR_MAX) wfull_q <= 1'b1;
        end
        if (st_q == ST_FLUSH) fl_q <= fl_q + 1'b1;
      end
      if (last_da) match_q <= flt_match;
    end
  end

  // Buffer port registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= wr;
      if (wr) begin
        waddr_q <= wptr_q;
        wdata_q <= oldest;
      end
    end
  end

  // Status, ownership and miss count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= 1'b0;
      len_q    <= '0;
      crc_ok_q <= 1'b0;
      runt_q   <= 1'b0;
      mout_q   <= MT_INDIV;
      miss_q   <= '0;
    end else begin
      if (notify) begin
        held_q   <= 1'b1;
        len_q    <= cnt_q;
        crc_ok_q <= crc_good;
        runt_q   <= runt_now;
        mout_q   <= match_q;
      end else if (host_release_i) begin
        held_q <= 1'b0;
      end
      if (last_da && flt_accept && held_q && miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
    end
  end

  assign buf_we_o    = we_q;
  assign buf_addr_o  = waddr_q;
  assign buf_wdata_o = wdata_q;
  assign frame_len_o = len_q;
  assign crc_ok_o    = crc_ok_q;
  assign runt_o      = runt_q;
  assign match_o     = mout_q;
  assign irq_o       = held_q;
  assign miss_cnt_o  = miss_q;

  AST_FLUSH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FLUSH |-> fl_q <= FL_LAST);  // R4
  AST_NO_WR_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_q) == ST_DROP |-> !buf_we_o);  // R3
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !host_release_i |=> irq_o);  // R8
  AST_LEN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(irq_o) |-> $stable(frame_len_o));  // R8
  AST_NO_WR_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(irq_o) |-> !buf_we_o);  // R9
  AST_MISS_ONLY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o != $past(miss_cnt_o) |-> $past(irq_o));  // R9

endmodule

// File: tb/test_eth_rx_filter.sv
module test_eth_rx_filter;

  localparam int CLK_PERIOD = 10;
  localparam int BUF_AW = 11;
  localparam int LEN_W  = 16;
  localparam int MISS_W = 8;

  localparam logic [47:0] OWN_DA = 48'h021A2B3C4D5E;
  localparam logic [47:0] BC_DA  = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC_DA  = 48'h01005E000007;
  localparam logic [47:0] OTH_DA = 48'h029988776655;

  // cfg = {ucast, bcast, mcast, promisc, bad_crc_irq, runt_irq}; da 0 own,1 bc,2 mc,3 other
  typedef struct packed {
    logic [1:0] da;
    logic [7:0] plen;
    logic       bad;
    logic [5:0] cfg;
    logic       keep;
    logic       irq;
    logic [1:0] mt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd46, 1'b0, 6'b111000, 1'b1, 1'b1, 2'd0},
    '{2'd1, 8'd50, 1'b0, 6'b111000, 1'b1, 1'b1, 2'd1},
    '{2'd2, 8'd50, 1'b0, 6'b111000, 1'b1, 1'b1, 2'd2},
    '{2'd3, 8'd50, 1'b0, 6'b111000, 1'b0, 1'b0, 2'd0},
    '{2'd3, 8'd50, 1'b0, 6'b000100, 1'b1, 1'b1, 2'd3},
    '{2'd0, 8'd50, 1'b0, 6'b011000, 1'b0, 1'b0, 2'd0},
    '{2'd1, 8'd50, 1'b0, 6'b101000, 1'b1, 1'b1, 2'd2},
    '{2'd0, 8'd50, 1'b1, 6'b111000, 1'b1, 1'b0, 2'd0},
    '{2'd0, 8'd50, 1'b1, 6'b111010, 1'b1, 1'b1, 2'd0},
    '{2'd0, 8'd45, 1'b0, 6'b111000, 1'b1, 1'b0, 2'd0},
    '{2'd0, 8'd45, 1'b0, 6'b111001, 1'b1, 1'b1, 2'd0},
    '{2'd3, 8'd50, 1'b0, 6'b111100, 1'b1, 1'b1, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic crs = 1'b0, vld = 1'b0;
  logic [7:0] dat = '0;
  logic ucast = 1'b0, bcast = 1'b0, mcast = 1'b0, promisc = 1'b0, bad_en = 1'b0, runt_en = 1'b0;
  logic release_p = 1'b0;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_addr;
  logic [7:0]        buf_wdata;
  logic [LEN_W-1:0]  frame_len;
  logic              crc_ok, runt, irq;
  logic [1:0]        match;
  logic [MISS_W-1:0] miss;

  int total = 0, bad = 0;
  logic [7:0] frm [0:255];
  int flen = 0;
  logic [7:0] cap [0:255];
  int ncap = 0;
  int last_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_filter #(.BUF_AW(BUF_AW), .LEN_W(LEN_W), .MISS_W(MISS_W)) i_eth_rx_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_crs_i(crs), .rx_valid_i(vld), .rx_data_i(dat),
    .station_addr_i(OWN_DA), .ucast_en_i(ucast), .bcast_en_i(bcast), .mcast_en_i(mcast),
    .promisc_en_i(promisc), .irq_bad_crc_en_i(bad_en), .irq_runt_en_i(runt_en),
    .host_release_i(release_p), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .frame_len_o(frame_len), .crc_ok_o(crc_ok), .runt_o(runt),
    .match_o(match), .irq_o(irq), .miss_cnt_o(miss)
  );

  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (buf_addr < 256) cap[buf_addr[7:0]] = buf_wdata;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input logic [1:0] sel, input int plen, input logic corrupt);
    logic [47:0] da;
    logic [31:0] c;
    case (sel)
      2'd0: da = OWN_DA;
      2'd1: da = BC_DA;
      2'd2: da = MC_DA;
      default: da = OTH_DA;
    endcase
    for (int i = 0; i < 6; i++) frm[i] = da[47-8*i -: 8];
    for (int i = 0; i < 6; i++) frm[6+i] = (i == 5) ? 8'h01 : (i == 0 ? 8'h02 : 8'h00);
    frm[12] = 8'h08;
    frm[13] = 8'h00;
    for (int i = 0; i < plen; i++) frm[14+i] = 8'((i * 7 + 3) & 255);
    flen = 14 + plen;
    c = '1;
    for (int i = 0; i < flen; i++) c = crc_upd(c, frm[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) frm[flen+i] = c[8*i +: 8];
    flen = flen + 4;
    if (corrupt) frm[20] = frm[20] ^ 8'h01;
  endtask

  task automatic send(input int nbytes);
    int k;
    ncap = 0;
    @(negedge clk);
    crs = 1'b1;
    vld = 1'b0;
    @(negedge clk);
    k = 0;
    for (int i = 0; i < 8 + nbytes; i++) begin
      vld = 1'b1;
      dat = (i < 7) ? 8'h55 : (i == 7 ? 8'hD5 : frm[i-8]);
      @(negedge clk);
      k++;
      if (k % 3 == 0) begin
        vld = 1'b0;
        dat = 8'hA5;
        @(negedge clk);
      end
    end
    vld = 1'b0;
    crs = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [5:0] c);
    {ucast, bcast, mcast, promisc, bad_en, runt_en} = c;
  endtask

  task automatic release_buf();
    release_p = 1'b1;
    @(negedge clk);
    release_p = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R8", "reset irq", irq, 0);
    chk(frame_len == '0, "R6", "reset len", frame_len, 0);
    chk(miss == '0, "R9", "reset miss", miss, 0);
    chk(buf_we == 1'b0, "R4", "reset we", buf_we, 0);

    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v].cfg);
      build(VEC[v].da, int'(VEC[v].plen), VEC[v].bad);
      send(flen);
      if (VEC[v].keep) begin
        mism = 0;
        for (int i = 0; i < flen; i++) if (cap[i] !== frm[i]) mism++;
        chk(ncap == flen, "R4", "write count", ncap, flen);
        chk(mism == 0, "R4", "buffer content mismatches", mism, 0);
        chk(cap[0] == frm[0], "R1", "first stored byte", cap[0], frm[0]);
      end else begin
        chk(ncap == 0, "R3", "rejected writes", ncap, 0);
      end
      chk(irq == VEC[v].irq, "R7", "irq", irq, VEC[v].irq);
      if (irq && VEC[v].irq) begin
        chk(frame_len == flen, "R6", "length", frame_len, flen);
        chk(runt == (flen < 64), "R6", "runt", runt, flen < 64);
        chk(crc_ok == !VEC[v].bad, "R5", "crc_ok", crc_ok, !VEC[v].bad);
        chk(match == VEC[v].mt, "R2", "match", match, VEC[v].mt);
        last_len = flen;
        release_buf();
        chk(irq == 1'b0, "R8", "irq after release", irq, 0);
      end else begin
        chk(frame_len == last_len, "R7", "status unchanged", frame_len, last_len);
      end
    end

    // Overrun while held
    set_cfg(6'b111000);
    build(2'd0, 50, 1'b0);
    send(flen);
    chk(irq == 1'b1, "R8", "held frame irq", irq, 1);
    last_len = flen;
    build(2'd0, 60, 1'b0);
    send(flen);
    chk(ncap == 0, "R9", "writes while held", ncap, 0);
    chk(miss == 1, "R9", "miss count", miss, 1);
    chk(frame_len == last_len, "R8", "len frozen", frame_len, last_len);
    chk(irq == 1'b1, "R8", "irq still held", irq, 1);
    build(2'd3, 50, 1'b0);
    send(flen);
    chk(miss == 1, "R9", "rejected not counted", miss, 1);
    release_buf();
    chk(irq == 1'b0, "R8", "release after overrun", irq, 0);

    // Short frame after the delimiter
    set_cfg(6'b000100);
    build(2'd0, 50, 1'b0);
    send(4);
    chk(ncap == 0, "R10", "short frame writes", ncap, 0);
    chk(irq == 1'b0, "R10", "short frame irq", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule